// File: doc/BRIEF.md
# Dual Nibble-Loaded Timer/Counter

This block holds two identical 12-bit up-counters that share one write port. The first is an event counter. It advances on falling edges of one of two external pins, and each pin passes through a two-flop synchronizer before its falling edge is detected. The second is an interval timer. It advances on falling edges of one of four prescaler taps, which arrive already synchronous to the clock.

Each unit has a reload value written four bits at a time as a low, a middle and a high slice, and a 4-bit command word. A unit counts upward from its reload value. When the count reaches all ones, the next qualifying edge copies the reload value back into the count, sets a sticky overflow flag and pulses that unit's interrupt request for one cycle. With a reload value P, a period is therefore 0x1000 − P edges. For example, 0xF16 gives 234 edges.

A status nibble reports each flag only while that unit's interrupt mask input is low. Software clears a flag by writing a 1 to its acknowledge bit.

Each unit is driven by a three-state machine:
- `ST_STOP` (idle, count held). It moves to `ST_LOAD` when the run bit is set.
- `ST_LOAD` (count takes the reload value, edges ignored). It moves to `ST_RUN` if the run bit is still set, and otherwise back to `ST_STOP`.
- `ST_RUN` (counting). It moves to `ST_STOP` when the run bit is cleared.

Top module: `tc_dual`

## Requirements
- R1: After reset, both counts, both reload values and both command words are zero, counting is disabled, `status` is 0000, and both interrupt outputs are low.
- R2: A write with `wr_addr` 0, 1 or 2 sets bits [3:0], [7:4] or [11:8] of the event counter's reload value. Addresses 4, 5 and 6 do the same for the timer.
- R3: Address 3 writes the event counter's command word and address 7 writes the timer's. Bit 3 is the run bit. Two cycles after a write that sets it in a stopped unit, the count equals the reload value.
- R4: In the event counter, command bit 0 selects the source: 0 selects `ext_pin[0]` and 1 selects `ext_pin[1]`. Falling edges on the unselected pin leave the count unchanged.
- R5: A falling edge on the selected external pin adds one to the count. The change is visible after the third rising clock edge that sees the pin low, counting the first edge that samples it low.
- R6: In the timer, command bits [1:0] select `rate_tap[n]`. The count rises by one at the first clock edge that samples the selected tap low after it was high.
- R7: An edge that arrives while the count is 0xFFF reloads the count from the reload value, pulses the unit's interrupt for exactly one cycle and sets its flag. Consecutive interrupts are 0x1000 − reload edges apart.
- R8: `status` bit 2 shows the event counter's flag ANDed with NOT `cnt_mask`, and bit 3 shows the timer's flag ANDed with NOT `tmr_mask`. Bits 1:0 read zero. A mask hides a flag but does not clear it.
- R9: An acknowledge write with `ack_bits[0]` = 1 clears the event counter's flag, and `ack_bits[1]` = 1 clears the timer's flag. A zero bit leaves its flag alone. An overflow in the same cycle as the clear wins, and the flag reads 1.
- R10: Clearing the run bit stops counting one cycle later and freezes the count. Setting the run bit again reloads the count from the reload value.
- R11: A new reload value written while a unit runs does not disturb the running count. It takes effect at the next overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: bit 2 picks the unit, bits 1:0 pick low, middle, high or command |
| wr_data | input | 4 | Write data |
| ack_en | input | 1 | Acknowledge write strobe |
| ack_bits | input | 2 | Bit 0 clears the counter flag, bit 1 clears the timer flag |
| cnt_mask | input | 1 | Interrupt mask of the event counter; hides its status bit |
| tmr_mask | input | 1 | Interrupt mask of the timer; hides its status bit |
| ext_pin | input | 2 | Asynchronous external event inputs |
| rate_tap | input | 4 | Synchronous prescaler taps |
| status | output | 4 | Bit 2 is the counter flag, bit 3 is the timer flag, bits 1:0 are zero |
| cnt_irq | output | 1 | One-cycle overflow request from the event counter |
| tmr_irq | output | 1 | One-cycle overflow request from the timer |
| cnt_value | output | 12 | Current count of the event counter |
| tmr_value | output | 12 | Current count of the timer |

## Verification
The results of this block fall due at different latencies, counted from the rising edge that samples the stimulus:
- An external-pin fall shows in `cnt_value` after the third such edge.
- A tap fall shows in `tmr_value` after the first.
- A run-bit write loads the reload value two edges after the write.
- `status`, the flag and the interrupt pulse all change on the same edge as the wrap.
- Masks act on `status` without any delay.

The bench holds a behavioural model that keeps pin-sample histories of these depths. It updates on each rising edge from the same inputs, and its prediction is compared with every output one nanosecond before the next rising edge. The inputs change only on falling edges, so each comparison falls inside a stable window.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } tc_state_t;

    localparam int CMD_EN_BIT = 3;
    localparam int STAT_BASE  = 2;

endpackage

// File: rtl/tc_edge.sv
module tc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    logic cur;
    logic prev_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_q <= '0;
                end else begin
                    sh_q[0] <= din;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sh_q[i] <= sh_q[i-1];
                    end
                end
            end
            assign cur = sh_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign cur = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cur;
        end
    end

    assign fall = prev_q & ~cur;

    // R5
    fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tc_unit.sv
module tc_unit
    import tc_pkg::*;
#(
    parameter int WIDTH = 12,
    parameter int NIB   = 4,
    parameter int NSRC  = 2,
    localparam int NSLICE = WIDTH / NIB,
    localparam int IDX_W  = $clog2(NSLICE + 1),
    localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NIB-1:0]   wr_data,
    input  logic             clr,
    input  logic             mask,
    input  logic [NSRC-1:0]  src_fall,
    output logic             flag_vis,
    output logic             irq,
    output logic [WIDTH-1:0] count
);

    tc_state_t        state_q, state_d;
    logic [WIDTH-1:0] preset_q;
    logic [WIDTH-1:0] count_q, count_d;
    logic             run_q;
    logic [SEL_W-1:0] sel_q;
    logic             flag_q;
    logic             irq_q;
    logic             ovf;
    logic             fall_sel;
    logic             cmd_we;
    logic [NSLICE-1:0] slice_we;

    genvar s;
    generate
        for (s = 0; s < NSLICE; s++) begin : g_slice_we
            assign slice_we[s] = wr_en && (wr_idx == IDX_W'(s));
        end
    endgenerate

    assign cmd_we   = wr_en && (wr_idx == IDX_W'(NSLICE));
    assign fall_sel = src_fall[sel_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
        end else begin
            for (int i = 0; i < NSLICE; i++) begin
                if (slice_we[i]) begin
                    preset_q[i*NIB +: NIB] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            sel_q <= '0;
        end else if (cmd_we) begin
            run_q <= wr_data[CMD_EN_BIT];
            sel_q <= wr_data[SEL_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: state_d = run_q ? ST_LOAD : ST_STOP;
            ST_LOAD: state_d = run_q ? ST_RUN  : ST_STOP;
            ST_RUN:  state_d = run_q ? ST_RUN  : ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    // state outputs: count update and overflow
    always_comb begin
        count_d = count_q;
        ovf     = 1'b0;
        unique case (state_q)
            ST_STOP: count_d = count_q;
            ST_LOAD: count_d = preset_q;
            ST_RUN: begin
                if (fall_sel) begin
                    if (count_q == '1) begin
                        ovf     = 1'b1;
                        count_d = preset_q;
                    end else begin
                        count_d = count_q + WIDTH'(1);
                    end
                end
            end
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            flag_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            irq_q   <= ovf;
            if (ovf) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag_vis = flag_q & ~mask;
    assign irq      = irq_q;
    assign count    = count_q;

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> $stable(count_q));

    // R7
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (count_q == $past(preset_q)));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (irq_q || (count_q == $past(count_q)) ||
                                 (count_q == $past(count_q) + WIDTH'(1))));

    // R9
    flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> irq_q);

endmodule

// File: rtl/tc_dual.sv
module tc_dual
    import tc_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int NIB         = 4,
    parameter int EXT_SRC     = 2,
    parameter int TAP_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NSLICE = WIDTH / NIB,
    localparam int IDX_W  = $clog2(NSLICE + 1),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NIB-1:0]     wr_data,
    input  logic               ack_en,
    input  logic [1:0]         ack_bits,
    input  logic               cnt_mask,
    input  logic               tmr_mask,
    input  logic [EXT_SRC-1:0] ext_pin,
    input  logic [TAP_SRC-1:0] rate_tap,
    output logic [NIB-1:0]     status,
    output logic               cnt_irq,
    output logic               tmr_irq,
    output logic [WIDTH-1:0]   cnt_value,
    output logic [WIDTH-1:0]   tmr_value
);

    logic [EXT_SRC-1:0] ext_fall;
    logic [TAP_SRC-1:0] tap_fall;
    logic               cnt_vis, tmr_vis;

    genvar i;
    generate
        for (i = 0; i < EXT_SRC; i++) begin : g_ext
            tc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (ext_pin[i]),
                .fall (ext_fall[i])
            );
        end
        for (i = 0; i < TAP_SRC; i++) begin : g_tap
            tc_edge #(.SYNC_STAGES(0)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (rate_tap[i]),
                .fall (tap_fall[i])
            );
        end
    endgenerate

    tc_unit #(.WIDTH(WIDTH), .NIB(NIB), .NSRC(EXT_SRC)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && !wr_addr[ADDR_W-1]),
        .wr_idx  (wr_addr[IDX_W-1:0]),
        .wr_data (wr_data),
        .clr     (ack_en && ack_bits[0]),
        .mask    (cnt_mask),
        .src_fall(ext_fall),
        .flag_vis(cnt_vis),
        .irq     (cnt_irq),
        .count   (cnt_value)
    );

    tc_unit #(.WIDTH(WIDTH), .NIB(NIB), .NSRC(TAP_SRC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && wr_addr[ADDR_W-1]),
        .wr_idx  (wr_addr[IDX_W-1:0]),
        .wr_data (wr_data),
        .clr     (ack_en && ack_bits[1]),
        .mask    (tmr_mask),
        .src_fall(tap_fall),
        .flag_vis(tmr_vis),
        .irq     (tmr_irq),
        .count   (tmr_value)
    );

    always_comb begin
        status                = '0;
        status[STAT_BASE]     = cnt_vis;
        status[STAT_BASE + 1] = tmr_vis;
    end

    // R8
    masked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_irq && !cnt_mask) |-> status[STAT_BASE]);

endmodule

// File: tb/tb_tc_dual.sv
`timescale 1ns/1ps
module tb_tc_dual;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [3:0]  wr_data;
    logic        ack_en;
    logic [1:0]  ack_bits;
    logic        cnt_mask, tmr_mask;
    logic [1:0]  ext_pin;
    logic [3:0]  rate_tap;
    logic [3:0]  status;
    logic        cnt_irq, tmr_irq;
    logic [11:0] cnt_value, tmr_value;

    always #2.5 clk = ~clk;

    tc_dual dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ack_en(ack_en), .ack_bits(ack_bits),
        .cnt_mask(cnt_mask), .tmr_mask(tmr_mask), .ext_pin(ext_pin),
        .rate_tap(rate_tap), .status(status), .cnt_irq(cnt_irq),
        .tmr_irq(tmr_irq), .cnt_value(cnt_value), .tmr_value(tmr_value)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    int    tick = 0;
    int    irq_seen [2];
    int    t_last, t_prev;
    int    tcyc = 0;
    bit    tap_run = 0;
    bit    done = 0;

    // behavioural reference: 0 = stopped, 1 = loading, 2 = running
    int          m_state [2];
    logic [11:0] m_cnt [2];
    logic [11:0] m_pre [2];
    logic [3:0]  m_cmd [2];
    logic        m_flag [2];
    logic        m_irq [2];
    logic [1:0]  h1, h2, h3;   // pin samples 1, 2, 3 edges back
    logic [3:0]  pt;           // tap samples 1 edge back

    task automatic model_reset();
        for (int u = 0; u < 2; u++) begin
            m_state[u] = 0; m_cnt[u] = '0; m_pre[u] = '0;
            m_cmd[u] = '0; m_flag[u] = 1'b0; m_irq[u] = 1'b0;
        end
        h1 = '0; h2 = '0; h3 = '0; pt = '0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic [1:0] fe;
            logic [3:0] ft;
            fe = h3 & ~h2;
            h3 = h2; h2 = h1; h1 = ext_pin;
            ft = pt & ~rate_tap;
            pt = rate_tap;
            for (int u = 0; u < 2; u++) begin
                logic f, en, hit;
                f   = (u == 0) ? fe[m_cmd[0][0]] : ft[m_cmd[1][1:0]];
                en  = m_cmd[u][3];
                hit = 1'b0;
                if (m_state[u] == 0) begin
                    if (en) m_state[u] = 1;
                end else if (m_state[u] == 1) begin
                    m_cnt[u] = m_pre[u];
                    m_state[u] = en ? 2 : 0;
                end else begin
                    if (f) begin
                        if (m_cnt[u] == 12'hFFF) begin
                            m_cnt[u] = m_pre[u];
                            hit = 1'b1;
                        end else begin
                            m_cnt[u] = m_cnt[u] + 12'd1;
                        end
                    end
                    if (!en) m_state[u] = 0;
                end
                if (hit) m_flag[u] = 1'b1;
                else if (ack_en && ack_bits[u]) m_flag[u] = 1'b0;
                m_irq[u] = hit;
            end
            if (wr_en) begin
                int u, idx;
                u   = int'(wr_addr[2]);
                idx = int'(wr_addr[1:0]);
                if (idx == 3) m_cmd[u] = wr_data;
                else m_pre[u][idx*4 +: 4] = wr_data;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison, 1 ns before the rising edge
    always @(negedge clk) begin
        #1;
        tick++;
        if (rst_n && !done) begin
            logic [3:0] es;
            es = {m_flag[1] & ~tmr_mask, m_flag[0] & ~cnt_mask, 2'b00};
            chk(cur_req, "status", 32'(status), 32'(es));
            chk(cur_req, "cnt_value", 32'(cnt_value), 32'(m_cnt[0]));
            chk(cur_req, "tmr_value", 32'(tmr_value), 32'(m_cnt[1]));
            chk(cur_req, "cnt_irq", 32'(cnt_irq), 32'(m_irq[0]));
            chk(cur_req, "tmr_irq", 32'(tmr_irq), 32'(m_irq[1]));
            if (cnt_irq) irq_seen[0]++;
            if (tmr_irq) begin
                irq_seen[1]++;
                t_prev = t_last;
                t_last = tick;
            end
        end
    end

    always @(negedge clk) begin
        if (tap_run) tcyc++;
        rate_tap = 4'(tcyc >> 2);
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(input logic [1:0] b);
        @(negedge clk);
        ack_en = 1'b1; ack_bits = b;
        @(negedge clk);
        ack_en = 1'b0; ack_bits = 2'b00;
    endtask

    task automatic efall(input int i);
        @(negedge clk);
        ext_pin[i] = 1'b0;
        idle(3);
        ext_pin[i] = 1'b1;
        idle(3);
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        int k;
        logic [11:0] held;
        irq_seen[0] = 0; irq_seen[1] = 0; t_last = 0; t_prev = 0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ack_en = 1'b0; ack_bits = '0; cnt_mask = 1'b0; tmr_mask = 1'b0;
        ext_pin = 2'b11;
        idle(4);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1", "status", 32'(status), 32'h0);
        chk("R1", "cnt_value", 32'(cnt_value), 32'h0);
        chk("R1", "tmr_value", 32'(tmr_value), 32'h0);
        chk("R1", "irqs", 32'({cnt_irq, tmr_irq}), 32'h0);

        // R2 nibble writes, R3 run bit and load timing
        cur_req = "R2";
        wr(3'd0, 4'hA); wr(3'd1, 4'hF); wr(3'd2, 4'hF);
        idle(2); #2;
        chk("R3", "cnt_value before run", 32'(cnt_value), 32'h0);
        cur_req = "R3";
        wr(3'd3, 4'b1000);
        idle(2); #2;
        chk("R2", "cnt_value loaded", 32'(cnt_value), 32'hFFA);

        // R4 unselected pin ignored, R5 counting
        cur_req = "R4";
        efall(1); efall(1); idle(2); #2;
        chk("R4", "pin1 ignored", 32'(cnt_value), 32'hFFA);
        cur_req = "R5";
        efall(0); idle(2); #2;
        chk("R5", "one fall", 32'(cnt_value), 32'hFFB);
        for (int n = 0; n < 4; n++) efall(0);
        idle(2); #2;
        chk("R5", "at all ones", 32'(cnt_value), 32'hFFF);
        chk("R7", "no irq yet", 32'(irq_seen[0]), 32'd0);
        cur_req = "R7";
        efall(0); idle(2); #2;
        chk("R7", "wrapped to reload", 32'(cnt_value), 32'hFFA);
        chk("R7", "one counter irq", 32'(irq_seen[0]), 32'd1);
        chk("R7", "status bit2", 32'(status), 32'h4);

        // R8 mask hides but keeps flag
        cur_req = "R8";
        cnt_mask = 1'b1; settle();
        chk("R8", "masked status", 32'(status), 32'h0);
        cnt_mask = 1'b0; settle();
        chk("R8", "unmasked status", 32'(status), 32'h4);

        // R9 acknowledge
        cur_req = "R9";
        ack(2'b10); settle();
        chk("R9", "other bit no clear", 32'(status), 32'h4);
        ack(2'b01); settle();
        chk("R9", "cleared", 32'(status), 32'h0);

        // R4 select second pin
        cur_req = "R4";
        wr(3'd3, 4'b1001); idle(2);
        efall(1); efall(1); efall(0); idle(2); #2;
        chk("R4", "pin1 selected", 32'(cnt_value), 32'hFFC);

        // R6 timer with tap 0, R7 period
        cur_req = "R6";
        wr(3'd4, 4'h6); wr(3'd5, 4'h1); wr(3'd6, 4'hF);
        tap_run = 1;
        wr(3'd7, 4'b1000);
        idle(2); #2;
        chk("R3", "timer loaded", 32'(tmr_value), 32'hF16);
        cur_req = "R7";
        idle(2 * 1872 + 100);
        chk("R7", "two timer irqs", 32'(irq_seen[1]), 32'd2);
        chk("R7", "irq period", 32'(t_last - t_prev), 32'd1872);

        // R6 switch to tap 1
        cur_req = "R6";
        wr(3'd7, 4'b1001); idle(200);

        // R10 stop and restart
        cur_req = "R10";
        wr(3'd7, 4'b0001); idle(2); #2;
        held = tmr_value;
        idle(150); #2;
        chk("R10", "count frozen", 32'(tmr_value), 32'(held));
        wr(3'd7, 4'b1000); idle(2); #2;
        chk("R10", "restart reload", 32'(tmr_value), 32'hF16);

        // R11 reload change mid-run, R9 set beats clear
        cur_req = "R11";
        wr(3'd4, 4'h0); wr(3'd5, 4'hF);
        idle(2); #2;
        chk("R11", "running count kept", 32'(tmr_value > 12'hF15), 32'd1);
        @(negedge clk);
        ack_en = 1'b1; ack_bits = 2'b10;
        k = irq_seen[1];
        while (irq_seen[1] == k) settle();
        chk("R11", "new reload used", 32'(tmr_value), 32'hFF0);
        chk("R9", "set wins over clear", 32'(status[3]), 32'd1);
        settle();
        chk("R9", "clear next cycle", 32'(status[3]), 32'd0);
        ack_en = 1'b0; ack_bits = 2'b00;
        idle(20);
        finish_run();
    end

endmodule